// File: doc/BRIEF.md
# Two-Wire Edge-Order Word Receiver

This block receives words over two undriven-clock wires, here called the strobe line and the marker line. It needs no shared clock and no fixed bit rate. A bit is signalled by how the marker line's pulse is placed relative to a strobe pulse. If the strobe pulses while the marker stays low, the bit is a zero. If the marker pulses entirely inside the strobe pulse, the bit is a one. If the marker rises inside the strobe pulse and stays high past the strobe's falling edge, the word ends.

Both wires are brought into the local clock domain through synchronising flops. Edges are then found by comparing each synchronised level with its previous sample. A small state machine tracks where the current strobe episode stands and sends shift, emit and abort strobes to a datapath. The datapath collects the bits and produces the finished word.

Senders drop leading zero bits, so a word may hold anywhere from 0 to 16 bits. The received value is right-aligned, with the upper byte used for control and the lower byte for data. An end-of-word marker produces a one-cycle valid pulse together with both fields and the bit count. Malformed traffic produces a one-cycle error pulse and the partial word is thrown away.

Top module: `edge_order_rx`

## Requirements
- R1: While and just after `rstN` is low, `wordValid` and `protoErr` are 0 and `ctrlField`, `dataField` and `bitCount` are 0.
- R2: A strobe (`lineA`) high episode during which the marker (`lineB`) stays low appends a 0 bit to the word being received.
- R3: A marker pulse that rises and falls entirely inside a strobe high episode appends a 1 bit.
- R4: The sequence strobe rise, marker rise, strobe fall, marker fall ends the word. It raises `wordValid` for exactly one cycle, and the output fields then hold their values until the next word ends.
- R5: Bits arrive MSB first and shift in at the LSB, so the value is right-aligned. `ctrlField` is bits 15:8 of that value, `dataField` is bits 7:0, and `bitCount` is the number of bits received (0 to 16).
- R6: After a word is emitted the collected bits and count are cleared, so the next word is unaffected by the previous one.
- R7: A 17th bit before the end-of-word marker pulses `protoErr` for one cycle and discards the word, so a following end-of-word marker reports `bitCount` 0 and zero fields.
- R8: A marker rise while the strobe is low, other than in the end-of-word tail, pulses `protoErr` and discards the partial word.
- R9: When strobe and marker rise in the same sample, the strobe is taken as having risen first.
- R10: Well-formed traffic never raises `protoErr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineA | input | 1 | Strobe wire, asynchronous |
| lineB | input | 1 | Marker wire, asynchronous |
| wordValid | output | 1 | One-cycle pulse when a word ends |
| ctrlField | output | 8 | Upper byte of the right-aligned word |
| dataField | output | 8 | Lower byte of the right-aligned word |
| bitCount | output | 5 | Number of bits in the emitted word |
| protoErr | output | 1 | One-cycle pulse on overflow or a stray marker edge |

## Verification
The hardest case to reach from the ports is the one where strobe and marker change inside the same synchroniser sample. That only happens when the two wires toggle in the same clock period. The bench reaches it by driving both wires on the same falling clock edge. It then confirms that the episode decodes as a 1 bit rather than an error.

Overflow needs a 17-bit run without an end-of-word marker. A stray marker edge needs a marker pulse while the strobe is idle. Both are built by directed tasks. Each is followed by an end-of-word marker, so that the discarded partial word can be observed through `bitCount`.

// File: rtl/eorx_pkg.sv
package eorx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_MARK,
    ST_MARK_DONE,
    ST_TAIL
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic emit;
    logic abort;
  } rxStrobe_t;

endpackage

// File: rtl/eorx_sync.sv
module eorx_sync #(
  parameter int NUM_LINES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] linesIn,
  output logic [NUM_LINES-1:0] lvl,
  output logic [NUM_LINES-1:0] rise,
  output logic [NUM_LINES-1:0] fall
);

  logic [NUM_LINES-1:0] prevLvl;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], linesIn[g]};
    end
    assign lvl[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= lvl;
  end

  assign rise = lvl & ~prevLvl;
  assign fall = ~lvl & prevLvl;

endmodule

// File: rtl/eorx_ctrl.sv
module eorx_ctrl
  import eorx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      aLvl,
  input  logic      bLvl,
  input  logic      aRise,
  input  logic      aFall,
  input  logic      bRise,
  input  logic      bFall,
  output rxStrobe_t stb
);

  rxState_t state, nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    case (state)
      ST_IDLE: begin
        if (aRise && bRise)  nextState = ST_MARK;
        else if (aRise)      nextState = ST_STROBE;
        else if (bRise)      stb.abort = 1'b1;
      end
      ST_STROBE: begin
        if (aFall) begin
          stb.shiftEn = 1'b1;
          nextState   = ST_IDLE;
        end else if (bRise) begin
          nextState = ST_MARK;
        end
      end
      ST_MARK: begin
        if (aFall && bFall) begin
          stb.shiftEn  = 1'b1;
          stb.shiftBit = 1'b1;
          nextState    = ST_IDLE;
        end else if (bFall) begin
          nextState = ST_MARK_DONE;
        end else if (aFall) begin
          nextState = ST_TAIL;
        end
      end
      ST_MARK_DONE: begin
        if (aFall) begin
          stb.shiftEn  = 1'b1;
          stb.shiftBit = 1'b1;
          nextState    = ST_IDLE;
        end else if (bRise) begin
          stb.abort = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_TAIL: begin
        if (bFall) begin
          stb.emit  = 1'b1;
          nextState = ST_IDLE;
        end else if (aRise) begin
          stb.abort = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.abort |=> (state == ST_IDLE)); // R8
  AST_TAIL_B_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TAIL) |-> (bLvl || bFall)); // R4
  AST_STROBE_A_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE) |-> (aLvl || aFall)); // R2

endmodule

// File: rtl/eorx_datapath.sv
module eorx_datapath
  import eorx_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int DATA_BITS = 8,
  localparam int CTRL_BITS = WORD_BITS - DATA_BITS,
  localparam int CNT_W     = $clog2(WORD_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            stb,
  output logic                 wordValid,
  output logic [CTRL_BITS-1:0] ctrlField,
  output logic [DATA_BITS-1:0] dataField,
  output logic [CNT_W-1:0]     bitCount,
  output logic                 protoErr
);

  logic [WORD_BITS-1:0] word;
  logic [CNT_W-1:0]     cnt;
  logic                 full;

  assign full = (cnt == CNT_W'(WORD_BITS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word      <= '0;
      cnt       <= '0;
      wordValid <= 1'b0;
      protoErr  <= 1'b0;
      ctrlField <= '0;
      dataField <= '0;
      bitCount  <= '0;
    end else begin
      wordValid <= 1'b0;
      protoErr  <= 1'b0;
      if (stb.abort || (stb.shiftEn && full)) begin
        word     <= '0;
        cnt      <= '0;
        protoErr <= 1'b1;
      end else if (stb.shiftEn) begin
        word <= {word[WORD_BITS-2:0], stb.shiftBit};
        cnt  <= cnt + 1'b1;
      end else if (stb.emit) begin
        ctrlField <= word[WORD_BITS-1:DATA_BITS];
        dataField <= word[DATA_BITS-1:0];
        bitCount  <= cnt;
        wordValid <= 1'b1;
        word      <= '0;
        cnt       <= '0;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid); // R4
  AST_CLEAR_AFTER_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.emit |=> (cnt == '0)); // R6
  AST_OVERFLOW_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftEn && full) |=> (protoErr && cnt == '0)); // R7

endmodule

// File: rtl/edge_order_rx.sv
module edge_order_rx
  import eorx_pkg::*;
#(
  parameter int WORD_BITS   = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CTRL_BITS  = WORD_BITS - DATA_BITS,
  localparam int CNT_W      = $clog2(WORD_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineA,
  input  logic                 lineB,
  output logic                 wordValid,
  output logic [CTRL_BITS-1:0] ctrlField,
  output logic [DATA_BITS-1:0] dataField,
  output logic [CNT_W-1:0]     bitCount,
  output logic                 protoErr
);

  logic [1:0] lvl, rise, fall;
  rxStrobe_t  stb;

  eorx_sync #(.NUM_LINES(2), .SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .linesIn({lineB, lineA}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  eorx_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .aLvl(lvl[0]), .bLvl(lvl[1]),
    .aRise(rise[0]), .aFall(fall[0]),
    .bRise(rise[1]), .bFall(fall[1]),
    .stb(stb)
  );

  eorx_datapath #(.WORD_BITS(WORD_BITS), .DATA_BITS(DATA_BITS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wordValid(wordValid), .ctrlField(ctrlField), .dataField(dataField),
    .bitCount(bitCount), .protoErr(protoErr)
  );

endmodule

// File: tb/tb_edge_order_rx.sv
module tb_edge_order_rx;

  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineA = 1'b0;
  logic       lineB = 1'b0;
  logic       wordValid, protoErr;
  logic [7:0] ctrlField, dataField;
  logic [4:0] bitCount;

  int  nChecks = 0, nFails = 0;
  int  validSeen = 0, errSeen = 0, longValid = 0;
  logic prevValid = 1'b0;
  logic [7:0] gotCtrl, gotData;
  logic [4:0] gotCnt;
  bit  finished = 0;

  always #10 clk = ~clk;

  edge_order_rx dut (
    .clk(clk), .rstN(rstN), .lineA(lineA), .lineB(lineB),
    .wordValid(wordValid), .ctrlField(ctrlField), .dataField(dataField),
    .bitCount(bitCount), .protoErr(protoErr)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (wordValid) begin
        validSeen++;
        gotCtrl = ctrlField;
        gotData = dataField;
        gotCnt  = bitCount;
        if (prevValid) longValid++;
      end
      if (protoErr) errSeen++;
      prevValid = wordValid;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(bit b);
    lineA = 1'b1; hold(P);
    if (b) begin
      lineB = 1'b1; hold(P);
      lineB = 1'b0; hold(P);
    end
    lineA = 1'b0; hold(P);
  endtask

  task automatic sendSync();
    lineA = 1'b1; hold(P);
    lineB = 1'b1; hold(P);
    lineA = 1'b0; hold(P);
    lineB = 1'b0; hold(P + 4);
  endtask

  task automatic sendWord(logic [16:0] val, int n);
    for (int i = n - 1; i >= 0; i--) sendBit(val[i]);
    sendSync();
  endtask

  task automatic expectWord(string req, int vBefore, int ctrlE, int dataE, int cntE);
    check(validSeen == vBefore + 1, {req, " valid pulses"}, validSeen - vBefore, 1);
    check(gotCtrl == ctrlE, {req, " ctrlField"}, gotCtrl, ctrlE);
    check(gotData == dataE, {req, " dataField"}, gotData, dataE);
    check(gotCnt == cntE, {req, " bitCount"}, gotCnt, cntE);
  endtask

  task automatic t_reset();
    hold(1);
    check(wordValid == 0, "R1 wordValid", wordValid, 0);
    check(protoErr == 0, "R1 protoErr", protoErr, 0);
    check(ctrlField == 0 && dataField == 0, "R1 fields", {ctrlField, dataField}, 0);
    check(bitCount == 0, "R1 bitCount", bitCount, 0);
    rstN = 1'b1; hold(3);
  endtask

  task automatic t_single_one();
    int v = validSeen;
    sendWord(17'h1, 1);
    expectWord("R3", v, 8'h00, 8'h01, 1);
  endtask

  task automatic t_zero_bits();
    int v = validSeen;
    sendWord(17'h4, 3);
    expectWord("R2", v, 8'h00, 8'h04, 3);
  endtask

  task automatic t_full_word();
    int v = validSeen;
    sendWord(17'hA5C3, 16);
    expectWord("R5", v, 8'hA5, 8'hC3, 16);
  endtask

  task automatic t_back_to_back();
    int v = validSeen;
    sendWord(17'h3, 2);
    expectWord("R6 first", v, 8'h00, 8'h03, 2);
    v = validSeen;
    sendWord(17'h2, 2);
    expectWord("R6 second", v, 8'h00, 8'h02, 2);
  endtask

  task automatic t_empty();
    int v = validSeen;
    sendSync();
    expectWord("R4 empty", v, 0, 0, 0);
  endtask

  task automatic t_hold_pulse();
    logic [7:0] c = ctrlField, d = dataField;
    hold(20);
    check(longValid == 0, "R4 single-cycle valid", longValid, 0);
    check(ctrlField == c && dataField == d, "R4 fields held",
          {ctrlField, dataField}, {c, d});
    check(wordValid == 0, "R4 valid low when idle", wordValid, 0);
  endtask

  task automatic t_clean();
    check(errSeen == 0, "R10 no error on clean traffic", errSeen, 0);
  endtask

  task automatic t_overflow();
    int e = errSeen, v;
    for (int i = 0; i < 17; i++) sendBit(1'b1);
    hold(4);
    check(errSeen == e + 1, "R7 overflow error", errSeen - e, 1);
    v = validSeen;
    sendSync();
    expectWord("R7 discarded", v, 0, 0, 0);
  endtask

  task automatic t_stray_b();
    int e = errSeen, v;
    sendBit(1'b1); sendBit(1'b1);
    lineB = 1'b1; hold(P);
    lineB = 1'b0; hold(P + 4);
    check(errSeen == e + 1, "R8 stray marker error", errSeen - e, 1);
    v = validSeen;
    sendSync();
    expectWord("R8 discarded", v, 0, 0, 0);
  endtask

  task automatic t_coincident();
    int e = errSeen, v = validSeen;
    lineA = 1'b1; lineB = 1'b1; hold(P);
    lineB = 1'b0; hold(P);
    lineA = 1'b0; hold(P);
    sendSync();
    check(errSeen == e, "R9 no error on coincident rise", errSeen - e, 0);
    expectWord("R9", v, 0, 1, 1);
  endtask

  initial begin
    hold(3);
    t_reset();
    t_single_one();
    t_zero_bits();
    t_full_word();
    t_back_to_back();
    t_empty();
    t_hold_pulse();
    t_clean();
    t_overflow();
    t_stray_b();
    t_coincident();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule